// File: doc/BRIEF.md
# PWM Fault Shutdown and Recovery Controller

This block watches four filtered fault levels and holds the PWM outputs off while any of them has tripped. A rising edge on a fault input latches a software-visible flag for that input and a shutdown state for it; the combined output enable drops as long as any shutdown state is held. Each fault can be set for automatic or manual recovery, and in manual recovery the rule depends on the fault's index and its 2-bit sample setting.

Recovery is aligned either to the next clock after a software flag clear or to a PWM half-cycle boundary, marked by a one-clock pulse from the PWM timebase. Automatic faults recover by themselves at a boundary once the fault level is low. Manual faults need a software flag clear first. For faults 0 and 2 the sample setting then picks release on the next clock (while the level is low) or release at the next boundary (whatever the level). Faults 1 and 3 release at a boundary only if the level is low there.

Top module: `pwm_fault_guard`

## Requirements
- R1: A rising edge on `fault_i[k]` sets `flag_o[k]` and the shutdown state of fault k at the next clock edge, so `pwm_en_o` is 0 after that edge.
- R2: With `auto_mode_i[k]`=1, fault k releases at a clock edge where `half_cycle_i`=1 and `fault_i[k]`=0. A boundary while the level is still 1 does not release it.
- R3: With `auto_mode_i[k]`=1, a software clear of `flag_o[k]` clears the flag but does not release the shutdown.
- R4: With `auto_mode_i[k]`=0, k in {0,2} and `sample_sel_i[2k+1:2k]`=00, the shutdown releases at the first clock edge after the flag has gone to 0 where `fault_i[k]`=0.
- R5: With `auto_mode_i[k]`=0, k in {0,2} and a sample setting of 01, 10 or 11, the shutdown releases at the first `half_cycle_i` pulse after the flag has gone to 0, whatever the fault level is. No release happens between boundaries.
- R6: With `auto_mode_i[k]`=0 and k in {1,3}, the shutdown releases only at a `half_cycle_i` pulse after the flag has gone to 0, and only if `fault_i[k]`=0 at that pulse.
- R7: A fault rising edge wins over a software clear in the same cycle, so the flag stays 1. A new rising edge during a pending manual release cancels it.
- R8: A `flag_clr_i[k]` strobe while `flag_o[k]`=0 has no effect on the flags or on `pwm_en_o`.
- R9: After reset all flags are 0 and `pwm_en_o`=1. `pwm_en_o` is 0 exactly while at least one fault holds a shutdown.
- R10: A one-clock `flag_clr_i[k]` strobe with no rising edge on fault k clears `flag_o[k]` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 4 | Filtered fault levels, bit k is fault k |
| half_cycle_i | input | 1 | One-clock pulse at each PWM half-cycle start |
| auto_mode_i | input | 4 | Bit k: 1 automatic recovery, 0 manual recovery |
| sample_sel_i | input | 8 | Bits [2k+1:2k]: sample setting of fault k |
| flag_clr_i | input | 4 | One-clock software clear strobes for the flags |
| flag_o | output | 4 | Fault flags, bit k is fault k |
| pwm_en_o | output | 1 | Combined PWM output enable, 1 = outputs allowed |

## Verification
The bench puts a fault rising edge and a software flag clear on the same clock. The expected result is that the flag stays set and the outputs stay off. It also re-trips a fault while its manual release waits for a boundary, then sends the boundary, and expects the outputs to stay off. A half-cycle pulse in the same cycle as a clear strobe is also covered. That boundary must not count, because the flag has not yet gone to 0. A behavioural per-cycle model judges each of these cases, and so do directed checks at the cycle where the registered state changes.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned FAULT_NUM = 4;
  localparam int unsigned SAMPLE_W  = 2;

  typedef enum logic [1:0] {
    REL_AUTO,       // level low at boundary
    REL_BUS,        // cleared flag, level low, any clock
    REL_BOUNDARY,   // cleared flag, next boundary, level ignored
    REL_GATED       // cleared flag, level low at boundary
  } rel_kind_e;
endpackage

// File: rtl/pwm_fault_chan.sv
module pwm_fault_chan
  import pwm_fault_pkg::*;
#(
  parameter int unsigned SEL_W     = SAMPLE_W,
  parameter bit          LVL_GATED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             half_cycle_i,
  input  logic             auto_mode_i,
  input  logic [SEL_W-1:0] sample_sel_i,
  input  logic             flag_clr_i,
  output logic             flag_o,
  output logic             dis_o
);
  logic fault_q, flag_q, dis_q;
  logic rise, pending, release_now;
  rel_kind_e kind;

  always_comb begin
    rise    = fault_i & ~fault_q;
    pending = dis_q & ~flag_q;
  end

  generate
    if (LVL_GATED) begin : g_gated
      logic unused_sel;
      assign unused_sel = ^sample_sel_i;
      always_comb kind = auto_mode_i ? REL_AUTO : REL_GATED;
    end else begin : g_sel
      always_comb begin
        if (auto_mode_i)                 kind = REL_AUTO;
        else if (sample_sel_i == '0)     kind = REL_BUS;
        else                             kind = REL_BOUNDARY;
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      REL_AUTO:     release_now = dis_q   & half_cycle_i & ~fault_i;
      REL_BUS:      release_now = pending & ~fault_i;
      REL_BOUNDARY: release_now = pending & half_cycle_i;
      default:      release_now = pending & half_cycle_i & ~fault_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      flag_q  <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      fault_q <= fault_i;
      if (rise) begin
        flag_q <= 1'b1;
        dis_q  <= 1'b1;
      end else begin
        if (flag_clr_i)  flag_q <= 1'b0;
        if (release_now) dis_q  <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;
  assign dis_o  = dis_q;
endmodule

// File: rtl/pwm_en_merge.sv
module pwm_en_merge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] dis_i,
  output logic         en_o
);
  assign en_o = ~|dis_i;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_FAULTS = FAULT_NUM,
  parameter int unsigned SEL_W    = SAMPLE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_FAULTS-1:0]       fault_i,
  input  logic                      half_cycle_i,
  input  logic [N_FAULTS-1:0]       auto_mode_i,
  input  logic [N_FAULTS*SEL_W-1:0] sample_sel_i,
  input  logic [N_FAULTS-1:0]       flag_clr_i,
  output logic [N_FAULTS-1:0]       flag_o,
  output logic                      pwm_en_o
);
  logic [N_FAULTS-1:0] dis;

  // odd-indexed faults need a low level at the boundary in manual mode
  for (genvar k = 0; k < N_FAULTS; k++) begin : g_chan
    pwm_fault_chan #(
      .SEL_W    (SEL_W),
      .LVL_GATED(k % 2 == 1)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fault_i     (fault_i[k]),
      .half_cycle_i(half_cycle_i),
      .auto_mode_i (auto_mode_i[k]),
      .sample_sel_i(sample_sel_i[k*SEL_W +: SEL_W]),
      .flag_clr_i  (flag_clr_i[k]),
      .flag_o      (flag_o[k]),
      .dis_o       (dis[k])
    );
  end

  pwm_en_merge #(.N(N_FAULTS)) u_merge (
    .dis_i(dis),
    .en_o (pwm_en_o)
  );
endmodule

module pwm_fault_guard_chk #(
  parameter int unsigned N_FAULTS = 4,
  parameter int unsigned SEL_W    = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_FAULTS-1:0]       fault_i,
  input logic                      half_cycle_i,
  input logic [N_FAULTS-1:0]       auto_mode_i,
  input logic [N_FAULTS*SEL_W-1:0] sample_sel_i,
  input logic [N_FAULTS-1:0]       flag_clr_i,
  input logic [N_FAULTS-1:0]       flag_o,
  input logic                      pwm_en_o
);
  logic [N_FAULTS-1:0] prev_q, rise, fast;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= fault_i;
  end

  always_comb begin
    rise = fault_i & ~prev_q;
    for (int k = 0; k < N_FAULTS; k++)
      fast[k] = (k % 2 == 0) && !auto_mode_i[k] && (sample_sel_i[k*SEL_W +: SEL_W] == '0);
  end

  for (genvar k = 0; k < N_FAULTS; k++) begin : g_prop
    a_r1_rise_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[k] |=> flag_o[k]);
    a_r1_rise_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[k] |=> !pwm_en_o);
    a_r10_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i[k] && !rise[k]) |=> !flag_o[k]);
    a_r8_idle_clear_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i[k] && !flag_o[k] && !rise[k]) |=> !flag_o[k]);
  end

  // R5: with no bus-cycle release channel configured, release waits for a boundary
  a_r5_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_en_o && !half_cycle_i && !(|fast)) |=> !pwm_en_o);
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.N_FAULTS(N_FAULTS), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .half_cycle_i(half_cycle_i),
  .auto_mode_i(auto_mode_i), .sample_sel_i(sample_sel_i), .flag_clr_i(flag_clr_i),
  .flag_o(flag_o), .pwm_en_o(pwm_en_o)
);

// File: tb/pwm_fault_guard_tb_top.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fault = '0, amode = '0, clr = '0, flag;
  logic       hc = 1'b0, en;
  logic [7:0] sel = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pwm_fault_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .half_cycle_i(hc),
    .auto_mode_i(amode), .sample_sel_i(sel), .flag_clr_i(clr),
    .flag_o(flag), .pwm_en_o(en)
  );

  // behavioural reference: per-fault tripped/flag/last-level
  bit m_flag[4], m_trip[4], m_last[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_flag[k] = 0; m_trip[k] = 0; m_last[k] = 0; end
    end else begin
      for (int k = 0; k < 4; k++) begin
        bit ok;
        int s;
        s = sel[2*k +: 2];
        if (amode[k])          ok = hc && !fault[k];
        else if (k % 2)        ok = !m_flag[k] && hc && !fault[k];
        else if (s == 0)       ok = !m_flag[k] && !fault[k];
        else                   ok = !m_flag[k] && hc;
        if (fault[k] && !m_last[k]) begin
          m_flag[k] = 1; m_trip[k] = 1;
        end else begin
          if (m_trip[k] && ok) m_trip[k] = 0;
          if (clr[k]) m_flag[k] = 0;
        end
        m_last[k] = fault[k];
      end
    end
  end

  function automatic logic [3:0] m_flags();
    return {m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
  endfunction
  function automatic logic m_en();
    return !(m_trip[0] || m_trip[1] || m_trip[2] || m_trip[3]);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then compare with the model away from the edge
  task automatic tick();
    @(posedge clk); #2;
    chk("R9 model enable", {3'b0, en}, {3'b0, m_en()});
    chk("R10 model flags", flag, m_flags());
  endtask

  task automatic strobe_clr(input logic [3:0] m);
    clr = m; tick(); clr = '0;
  endtask
  task automatic boundary();
    hc = 1'b1; tick(); hc = 1'b0;
  endtask

  task automatic do_reset(input logic [3:0] am, input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; fault = '0; clr = '0; hc = 1'b0; amode = am; sel = s;
    @(negedge clk); rst_n = 1'b1;
    tick();
  endtask

  initial begin
    fork
      begin
        // reset state
        do_reset(4'h0, 8'h00);
        chk("R9 reset enable", {3'b0, en}, 4'h1);
        chk("R9 reset flags", flag, 4'h0);

        // R8: clear strobes on zero flags
        strobe_clr(4'hf);
        chk("R8 idle clear flags", flag, 4'h0);
        chk("R8 idle clear enable", {3'b0, en}, 4'h1);

        // automatic fault 0
        do_reset(4'hf, 8'h00);
        fault[0] = 1; tick();
        chk("R1 flag set", flag, 4'h1);
        chk("R1 enable off", {3'b0, en}, 4'h0);
        boundary();
        chk("R2 boundary while high", {3'b0, en}, 4'h0);
        strobe_clr(4'h1);
        chk("R3 flag cleared", flag, 4'h0);
        chk("R3 still disabled", {3'b0, en}, 4'h0);
        fault[0] = 0; tick();
        chk("R2 low without boundary", {3'b0, en}, 4'h0);
        boundary();
        chk("R2 release at boundary", {3'b0, en}, 4'h1);

        // manual fault 0, sample 00
        do_reset(4'h0, 8'h00);
        fault[0] = 1; tick();
        strobe_clr(4'h1);
        chk("R10 manual flag cleared", flag, 4'h0);
        chk("R4 held after clear", {3'b0, en}, 4'h0);
        tick();
        chk("R4 level high blocks", {3'b0, en}, 4'h0);
        fault[0] = 0; tick();
        chk("R4 release next clock", {3'b0, en}, 4'h1);

        // manual fault 2, sample 01; boundary in the clear cycle does not count
        do_reset(4'h0, 8'h10);
        fault[2] = 1; tick();
        clr = 4'h4; hc = 1'b1; tick(); clr = '0; hc = 1'b0;
        chk("R5 same-cycle boundary ignored", {3'b0, en}, 4'h0);
        tick(); tick();
        chk("R5 no release between boundaries", {3'b0, en}, 4'h0);
        boundary();
        chk("R5 release with level high", {3'b0, en}, 4'h1);

        // manual fault 1
        do_reset(4'h0, 8'h00);
        fault[1] = 1; tick();
        strobe_clr(4'h2);
        boundary();
        chk("R6 level high at boundary", {3'b0, en}, 4'h0);
        fault[1] = 0; tick();
        chk("R6 low without boundary", {3'b0, en}, 4'h0);
        boundary();
        chk("R6 release", {3'b0, en}, 4'h1);

        // R7: rise and clear together on fault 3
        do_reset(4'h0, 8'h00);
        fault[3] = 1; tick();
        fault[3] = 0; tick();
        fault[3] = 1; clr = 4'h8; tick(); clr = '0;
        chk("R7 rise beats clear", flag, 4'h8);
        chk("R7 rise beats clear enable", {3'b0, en}, 4'h0);

        // R7: re-fault cancels pending release on fault 2, sample 10
        do_reset(4'h0, 8'h20);
        fault[2] = 1; tick();
        fault[2] = 0; tick();
        strobe_clr(4'h4);
        fault[2] = 1; tick();
        fault[2] = 0;
        boundary();
        chk("R7 cancelled release", {3'b0, en}, 4'h0);
        chk("R7 flag re-set", flag, 4'h4);

        // mixed: two faults, enable only after both release
        do_reset(4'h1, 8'h00);
        fault[0] = 1; fault[1] = 1; tick();
        fault = '0; boundary();
        chk("R9 one fault still held", {3'b0, en}, 4'h0);
        strobe_clr(4'h2);
        boundary();
        chk("R9 all released", {3'b0, en}, 4'h1);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule